// File: doc/BRIEF.md
# JK-Input Shift/Load Register

This block is a register of `WIDTH` stages (four by default) that share one clock. It has two synchronous modes, chosen by a single mode input. In shift mode, each rising clock edge moves every stage's value one place toward the most significant stage. The first stage takes a new bit from a JK-style serial input pair. In load mode, each rising clock edge copies a parallel input word into all stages at once.

An active-low master reset clears every stage immediately, without waiting for the clock. Besides the stage values, the block drives the inverse of the last stage as a separate registered output.

The serial pair has one true input and one inverted input. Tying the two together gives a plain data input. Driving them differently gives hold or toggle behaviour on the first stage. A user can therefore build a serial-in/parallel-out or parallel-in/serial-out path, a counter, or a storage stage from the same part.

Top module: `jkshift_reg`

## Requirements
- R1: With `shift_en` = 1, on each rising edge of `clk`, stage i (for 1 ≤ i < WIDTH) takes the value stage i-1 held before that edge.
- R2: With `shift_en` = 1, stage 0's next value depends on {`j_in`, `kb_in`} as follows: 00 gives 0, 11 gives 1, 01 holds the current stage 0, and 10 toggles the current stage 0.
- R3: With `shift_en` = 0, each rising edge loads `par_in[i]` into stage i for every i, and `j_in`/`kb_in` have no effect on the result.
- R4: When `rst_n` goes low, every stage clears to 0 at once, with no clock edge needed. While `rst_n` stays low, the stages stay at 0.
- R5: Reset takes priority over both load and shift. The first rising edge after `rst_n` returns high performs a normal load or shift.
- R6: `q_last_n` always equals the inverse of `q_out[WIDTH-1]`, including while reset is held, when it is 1.
- R7: The mode, serial and parallel inputs may change freely between edges. Each edge acts only on the values present at that edge, so alternating the mode on consecutive edges works.
- R8: The stage count is the parameter `WIDTH` (default 4, minimum 2). Shift direction and the serial-input rules are the same at any width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared rising-edge clock |
| rst_n | input | 1 | Asynchronous master clear, active low |
| shift_en | input | 1 | Mode select: 1 = shift, 0 = parallel load |
| j_in | input | 1 | Serial input, true polarity |
| kb_in | input | 1 | Serial input, inverted polarity |
| par_in | input | WIDTH | Parallel load word, bit i goes to stage i |
| q_out | output | WIDTH | Stage values, bit i is stage i |
| q_last_n | output | 1 | Registered inverse of the last stage |

## Verification
Every load or shift result appears on `q_out` and `q_last_n` one rising edge after the inputs that cause it. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and compares both outputs against its own reference model at the next falling edge, before any input changes again.

The reset clear is due with no edge at all. It is checked a few nanoseconds after `rst_n` drops in the middle of a clock phase. A further edge is then issued with reset still held, to confirm reset priority. The first edge after release is compared like any other.

// File: rtl/jkshift_pkg.sv
package jkshift_pkg;

  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_e;

  // Next value of the first stage from the serial pair (kb is active low).
  function automatic logic serial_next(input logic j, input logic kb, input logic cur);
    logic nxt;
    case ({j, kb})
      2'b00:   nxt = 1'b0;
      2'b11:   nxt = 1'b1;
      2'b01:   nxt = cur;
      default: nxt = ~cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/jkshift_cell.sv
module jkshift_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end

endmodule

// File: rtl/jkshift_feed.sv
module jkshift_feed
  import jkshift_pkg::*;
(
  input  logic shift_en,
  input  logic j_in,
  input  logic kb_in,
  input  logic par_bit,
  input  logic q_now,
  output logic d_next
);

  mode_e mode;

  always_comb begin
    mode = mode_e'(shift_en);
    if (mode == MODE_SHIFT) d_next = serial_next(j_in, kb_in, q_now);
    else                    d_next = par_bit;
  end

endmodule

// File: rtl/jkshift_reg.sv
module jkshift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             j_in,
  input  logic             kb_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q_out,
  output logic             q_last_n
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] d_vec;
  logic [WIDTH-1:0] q_vec;
  logic             head_d;

  jkshift_feed u_feed (
    .shift_en (shift_en),
    .j_in     (j_in),
    .kb_in    (kb_in),
    .par_bit  (par_in[0]),
    .q_now    (q_vec[0]),
    .d_next   (head_d)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign d_vec[i] = head_d;
    end else begin : g_body
      assign d_vec[i] = shift_en ? q_vec[i-1] : par_in[i];
    end

    jkshift_cell #(.RST_VAL(1'b0)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (d_vec[i]),
      .q     (q_vec[i])
    );
  end

  // Separate flop for the inverted last stage, so that output is registered too.
  jkshift_cell #(.RST_VAL(1'b1)) u_comp (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (~d_vec[MSB]),
    .q     (q_last_n)
  );

  assign q_out = q_vec;

endmodule

// File: rtl/jkshift_reg_chk.sv
module jkshift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             j_in,
  input logic             kb_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] q_out,
  input logic             q_last_n
);

  a_r1_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0]));

  a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && j_in && !kb_in) |=> q_out[0] != $past(q_out[0]));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !j_in && kb_in) |=> q_out[0] == $past(q_out[0]));

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> q_out == $past(par_in));

  a_r4_clear_held: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (q_out == '0 && q_last_n)));

  a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
    q_last_n == ~q_out[WIDTH-1]);

endmodule

bind jkshift_reg jkshift_reg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_en (shift_en),
  .j_in     (j_in),
  .kb_in    (kb_in),
  .par_in   (par_in),
  .q_out    (q_out),
  .q_last_n (q_last_n)
);

// File: tb/jkshift_reg_tb_top.sv
module jkshift_reg_tb_top;

  localparam int W = 4;
  localparam int NVEC = 14;
  // Vector fields: {shift_en, j, kb, par[3:0]}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_00_1010, // load
    7'b1_11_0000, // shift, D=1
    7'b1_00_1111, // shift, D=0
    7'b1_10_0000, // toggle
    7'b1_10_0000, // toggle again
    7'b1_01_0000, // hold
    7'b0_10_0110, // load, serial pair ignored
    7'b1_01_1001, // mode switch: shift hold
    7'b0_11_1001, // mode switch: load
    7'b1_10_0000, // toggle
    7'b0_00_0001, // load
    7'b1_11_1110, // shift D=1
    7'b1_11_1110, // shift D=1
    7'b1_11_1110  // shift D=1
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         shift_en = 1'b0;
  logic         j_in = 1'b0;
  logic         kb_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q_out;
  logic         q_last_n;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  jkshift_reg #(.WIDTH(W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .j_in     (j_in),
    .kb_in    (kb_in),
    .par_in   (par_in),
    .q_out    (q_out),
    .q_last_n (q_last_n)
  );

  task automatic check(input string req, input logic [W-1:0] exp_q);
    checks++;
    if (q_out !== exp_q || q_last_n !== ~exp_q[W-1]) begin
      fails++;
      $display("FAIL %s: q_out=%b q_last_n=%b expected q_out=%b q_last_n=%b",
               req, q_out, q_last_n, exp_q, ~exp_q[W-1]);
    end
  endtask

  function automatic logic [W-1:0] ref_next(input logic se, input logic j, input logic kb,
                                            input logic [W-1:0] par, input logic [W-1:0] cur);
    logic [W-1:0] n;
    logic b0;
    if (!se) return par;
    if (j == kb)      b0 = j;
    else if (kb)      b0 = cur[0];
    else              b0 = ~cur[0];
    n = {cur[W-2:0], b0};
    return n;
  endfunction

  // Drive on falling edge, one rising edge, compare at the following falling edge.
  task automatic step(input logic [6:0] v, input string req);
    shift_en = v[6];
    j_in     = v[5];
    kb_in    = v[4];
    par_in   = v[3:0];
    @(posedge clk);
    model = ref_next(v[6], v[5], v[4], v[3:0], model);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 reset state", '0);
    rst_n = 1'b1;
    model = '0;

    // R1 R2 R3 R7: table walk, mode alternates on consecutive edges
    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k], $sformatf("R1/R2/R3/R7 vector %0d", k));
    end

    // R2: toggle from a known 0
    step(7'b0_00_0000, "R3 load zero");
    step(7'b1_10_0000, "R2 toggle 0->1");
    step(7'b1_01_0000, "R2 hold at 1");
    step(7'b1_00_0000, "R2 force 0");

    // R3: serial pair ignored in load mode, each JK combination
    for (int c = 0; c < 4; c++) begin
      step({1'b0, c[1:0], 4'b1011}, "R3 load ignores serial pair");
    end

    // R4: mid-cycle asynchronous clear, no clock edge
    step(7'b0_00_1111, "R3 load ones");
    @(posedge clk);
    model = 4'b1111;
    #4;
    rst_n = 1'b0;
    #2;
    model = '0;
    check("R4 async clear mid-cycle", '0);
    check("R6 complement during reset", '0);

    // R5: edge with reset held and load requested keeps zero
    @(negedge clk);
    shift_en = 1'b0;
    par_in   = 4'b1111;
    @(posedge clk);
    @(negedge clk);
    check("R5 reset beats load", '0);
    shift_en = 1'b1; j_in = 1'b1; kb_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5 reset beats shift", '0);

    // R5: first edge after release is normal
    rst_n = 1'b1;
    step(7'b1_11_0000, "R5 first edge after release shifts");
    step(7'b0_00_0101, "R5 load after release");
    step(7'b1_00_0000, "R8 last stage shifted out");
    step(7'b1_00_0000, "R6 complement after shift");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule